// File: doc/BRIEF.md
# Serial Link Status and Control Register File

This block is the register file that sits beside a first-generation serial storage link. It holds sixteen 32-bit slots addressed by a 4-bit index. A single read/write access port is shared by the command decoder and the maintenance serial path. Through this port, software reads a live status word, reads and clears sticky error flags, and programs the link control fields. It also loads the self-test configuration and the physical-layer control bits.

Side-band inputs report the state of the physical layer:

- a ready flag and a device-detect flag;
- a 2-bit power state;
- a 32-bit vector of one-cycle error events.

The block drives these outputs:

- an interface hard-reset level and a PHY offline request;
- partial and slumber disables;
- transmit enable and force-ready;
- the transmit-only pattern mode;
- a one-cycle self-test start pulse, together with the three self-test option bits and the two pattern words.

Read data returns one cycle after the request, flagged by `rd_valid`. Writes take effect at the clock edge that samples them.

Top module: `slr_regfile`

## Requirements
- R1: A read (acc_en=1, acc_wr=0) at index A returns the slot's contents on rd_data with rd_valid high in the following cycle. Indices 7, 8 and 10 to 15 read 0, and writes to them have no effect. Writes to the status slot (index 0) have no effect.
- R2: Status (index 0) bits 3:0 follow a fixed priority. They read 0100 when the control detect field equals 0100. Otherwise they read 0011 when phy_rdy or force_rdy is high, then 0001 when only dev_detect is high, and 0000 when neither is high.
- R3: When phy_rdy or force_rdy is high, status bits 7:4 read 0001. In that case, status bits 11:8 read 0001, 0010 or 0110 for pwr_state 00 (active), 01 (partial) or 10 (slumber), and 0000 for pwr_state 11. When neither is high, bits 11:4 read 0. Status bits 31:12 are always 0.
- R4: Error slot (index 1) bits 0, 1, 8 to 11, 16 and 18 to 25 are set by the matching err_evt bit and cleared by writing 1 to them. Bit 17 is plain read/write. All other bits read 0.
- R5: If an event and a write-1 clear reach the same error bit in one cycle, the bit stays set.
- R6: Writing the control slot (index 2) with bit 0 set raises if_reset. The output stays high until a later control write with bit 0 clear. A control write with bits 3:0 equal to 0100 raises phy_offline.
- R7: Control bits 7:4 reset to 0001. Control bits 11:8 equal to 0001, 0010 or 0011 drive partial_dis, slumber_dis or both. The control slot reads back bits 11:0 with the upper bits 0.
- R8: The self-test option slot (index 3) keeps only bit 20 (bist_lpbk), bit 21 (bist_scram) and bit 23 (bist_txonly), and reads 0 elsewhere. Pattern slots 4 and 5 hold full words driven onto bist_pat0 and bist_pat1.
- R9: Writing 1 to system control (index 6) bit 0 produces a bist_start pulse one cycle long in the cycle after the write. That bit reads back 0.
- R10: PHY control (index 9) bit 0 drives tx_enable and resets to 1. Bit 1 drives force_rdy and resets to 0. The slot reads back only these two bits.
- R11: txonly_mode is system control bit 3 gated by force_rdy, so it is high only while force_rdy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access request |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Slot index |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| phy_rdy | input | 1 | Physical layer communication established |
| dev_detect | input | 1 | Device presence detected |
| pwr_state | input | 2 | Link power state |
| err_evt | input | 32 | Error event pulses |
| if_reset | output | 1 | Interface hard reset held |
| phy_offline | output | 1 | PHY offline request |
| partial_dis | output | 1 | Partial power state disallowed |
| slumber_dis | output | 1 | Slumber power state disallowed |
| tx_enable | output | 1 | Transmitter enable |
| force_rdy | output | 1 | Force PHY ready |
| txonly_mode | output | 1 | Transmit-only pattern mode active |
| bist_start | output | 1 | Self-test frame send pulse |
| bist_lpbk | output | 1 | Self-test loopback option |
| bist_scram | output | 1 | Self-test scrambler option |
| bist_txonly | output | 1 | Self-test transmit-only option |
| bist_pat0 | output | 32 | Self-test pattern word 0 |
| bist_pat1 | output | 32 | Self-test pattern word 1 |

## Verification
The status encoder is exercised across four input sets, each of which separates one rule from the others:

- No device at all.
- A detected device without a ready PHY, which shows that speed and power fields are suppressed.
- A ready PHY in each of the three power states, which shows the IPM mapping.
- Force-ready with the PHY input low, which shows that the override counts as ready.

The error slot is first flooded with an all-ones event vector, which separates the sticky bits from the dead ones. Partial clears then show that only the written ones fall, and a write to bit 17 shows plain storage. A clear that coincides with an event on the same bit shows the event's priority.

Control writes alternate between a reset-holding value, an offline value and each power-disable code, so that every output is seen both raised and dropped.

// File: rtl/slr_pkg.sv
package slr_pkg;

  localparam int unsigned SLR_DW   = 32;
  localparam int unsigned SLR_AW   = 4;
  localparam int unsigned SLR_NPAT = 2;

  // slot indices
  localparam logic [SLR_AW-1:0] ADR_STAT = 4'h0;
  localparam logic [SLR_AW-1:0] ADR_SERR = 4'h1;
  localparam logic [SLR_AW-1:0] ADR_SCTL = 4'h2;
  localparam logic [SLR_AW-1:0] ADR_TCTL = 4'h3;
  localparam logic [SLR_AW-1:0] ADR_PAT0 = 4'h4;
  localparam logic [SLR_AW-1:0] ADR_SYS  = 4'h6;
  localparam logic [SLR_AW-1:0] ADR_PHY  = 4'h9;

  // error slot bit classes
  localparam logic [SLR_DW-1:0] SERR_W1C = 32'h03FD_0F03;
  localparam logic [SLR_DW-1:0] SERR_RW  = 32'h0002_0000;

  // self-test option bit positions
  localparam int unsigned TCTL_LPBK  = 20;
  localparam int unsigned TCTL_SCRAM = 21;
  localparam int unsigned TCTL_TXO   = 23;

  // system control bit positions
  localparam int unsigned SYS_GO  = 0;
  localparam int unsigned SYS_TXO = 3;

  typedef enum logic [1:0] {
    PWR_ACTIVE  = 2'b00,
    PWR_PARTIAL = 2'b01,
    PWR_SLUMBER = 2'b10,
    PWR_RSVD    = 2'b11
  } pwr_e;

  typedef struct packed {
    logic [3:0] ipm;
    logic [3:0] spd;
    logic [3:0] det;
  } lnk_fields_t;

  localparam logic [3:0] DET_NONE    = 4'h0;
  localparam logic [3:0] DET_PRESENT = 4'h1;
  localparam logic [3:0] DET_ESTAB   = 4'h3;
  localparam logic [3:0] DET_OFFLINE = 4'h4;
  localparam logic [3:0] SPD_GEN1    = 4'h1;

endpackage

// File: rtl/slr_status_enc.sv
module slr_status_enc
  import slr_pkg::*;
#(
  parameter int unsigned DW = SLR_DW
) (
  input  logic          phy_rdy,
  input  logic          force_rdy,
  input  logic          dev_detect,
  input  logic          offline,
  input  logic [1:0]    pwr_state,
  output logic [DW-1:0] stat_word
);

  localparam int unsigned FW = $bits(lnk_fields_t);

  logic        link_up;
  lnk_fields_t fld;

  assign link_up = phy_rdy | force_rdy;

  always_comb begin
    fld = '0;
    if (offline)         fld.det = DET_OFFLINE;
    else if (link_up)    fld.det = DET_ESTAB;
    else if (dev_detect) fld.det = DET_PRESENT;
    else                 fld.det = DET_NONE;

    if (link_up) begin
      fld.spd = SPD_GEN1;
      case (pwr_e'(pwr_state))
        PWR_ACTIVE:  fld.ipm = 4'h1;
        PWR_PARTIAL: fld.ipm = 4'h2;
        PWR_SLUMBER: fld.ipm = 4'h6;
        default:     fld.ipm = 4'h0;
      endcase
    end
  end

  assign stat_word = {{(DW-FW){1'b0}}, fld};

endmodule

// File: rtl/slr_err_reg.sv
module slr_err_reg
  import slr_pkg::*;
#(
  parameter int unsigned     DW       = SLR_DW,
  parameter logic [DW-1:0]   W1C_MASK = SERR_W1C,
  parameter logic [DW-1:0]   RW_MASK  = SERR_RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] evt,
  output logic [DW-1:0] err_q
);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    if (W1C_MASK[i]) begin : g_sticky
      logic bit_d, bit_q;
      always_comb begin
        bit_d = bit_q;
        if (wr_en && wdata[i]) bit_d = 1'b0;
        if (evt[i])            bit_d = 1'b1;   // event has priority
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign err_q[i] = bit_q;
    end else if (RW_MASK[i]) begin : g_plain
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     bit_q <= 1'b0;
        else if (wr_en) bit_q <= wdata[i];
      end
      assign err_q[i] = bit_q;
    end else begin : g_zero
      assign err_q[i] = 1'b0;
    end
  end

endmodule

// File: rtl/slr_ctl_regs.sv
module slr_ctl_regs
  import slr_pkg::*;
#(
  parameter int unsigned DW   = SLR_DW,
  parameter int unsigned AW   = SLR_AW,
  parameter int unsigned NPAT = SLR_NPAT
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wdata,
  output lnk_fields_t        ctl_q,
  output logic [2:0]         tctl_q,     // {txonly, scram, lpbk}
  output logic [NPAT*DW-1:0] pat_flat,
  output logic               sys_txo_q,
  output logic [1:0]         phy_q,      // {force_rdy, tx_en}
  output logic               go_q
);

  localparam lnk_fields_t CTL_RST = '{ipm: 4'h0, spd: SPD_GEN1, det: 4'h0};
  localparam logic [1:0]  PHY_RST = 2'b01;

  logic        wr_ctl, wr_tctl, wr_sys, wr_phy;
  lnk_fields_t ctl_d;
  logic [2:0]  tctl_d;
  logic        sys_txo_d, go_d;
  logic [1:0]  phy_d;

  assign wr_ctl  = wr_en && (wr_addr == ADR_SCTL);
  assign wr_tctl = wr_en && (wr_addr == ADR_TCTL);
  assign wr_sys  = wr_en && (wr_addr == ADR_SYS);
  assign wr_phy  = wr_en && (wr_addr == ADR_PHY);

  always_comb begin
    ctl_d     = wr_ctl  ? lnk_fields_t'(wdata[$bits(lnk_fields_t)-1:0]) : ctl_q;
    tctl_d    = wr_tctl ? {wdata[TCTL_TXO], wdata[TCTL_SCRAM], wdata[TCTL_LPBK]} : tctl_q;
    sys_txo_d = wr_sys  ? wdata[SYS_TXO] : sys_txo_q;
    phy_d     = wr_phy  ? wdata[1:0] : phy_q;
    go_d      = wr_sys && wdata[SYS_GO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= CTL_RST;
      tctl_q    <= '0;
      sys_txo_q <= 1'b0;
      phy_q     <= PHY_RST;
      go_q      <= 1'b0;
    end else begin
      ctl_q     <= ctl_d;
      tctl_q    <= tctl_d;
      sys_txo_q <= sys_txo_d;
      phy_q     <= phy_d;
      go_q      <= go_d;
    end
  end

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    localparam logic [AW-1:0] MY_ADDR = ADR_PAT0 + AW'(g);
    logic          en;
    logic [DW-1:0] pat_q;
    assign en = wr_en && (wr_addr == MY_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pat_q <= '0;
      else if (en) pat_q <= wdata;
    end
    assign pat_flat[g*DW +: DW] = pat_q;
  end

endmodule

// File: rtl/slr_regfile.sv
module slr_regfile
  import slr_pkg::*;
#(
  parameter int unsigned DATA_W = SLR_DW,
  parameter int unsigned ADDR_W = SLR_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              phy_rdy,
  input  logic              dev_detect,
  input  logic [1:0]        pwr_state,
  input  logic [DATA_W-1:0] err_evt,
  output logic              if_reset,
  output logic              phy_offline,
  output logic              partial_dis,
  output logic              slumber_dis,
  output logic              tx_enable,
  output logic              force_rdy,
  output logic              txonly_mode,
  output logic              bist_start,
  output logic              bist_lpbk,
  output logic              bist_scram,
  output logic              bist_txonly,
  output logic [DATA_W-1:0] bist_pat0,
  output logic [DATA_W-1:0] bist_pat1
);

  localparam int unsigned NPAT = SLR_NPAT;
  localparam int unsigned FW   = $bits(lnk_fields_t);

  logic                   wr_en, rd_en;
  logic [DATA_W-1:0]      stat_word, err_q;
  lnk_fields_t            ctl_q;
  logic [2:0]             tctl_q;
  logic [NPAT*DATA_W-1:0] pat_flat;
  logic                   sys_txo_q;
  logic [1:0]             phy_q;
  logic                   go_q;
  logic [DATA_W-1:0]      rd_mux, rd_data_d;
  logic                   rd_valid_q;
  logic [DATA_W-1:0]      rd_data_q;

  assign wr_en = acc_en &&  acc_wr;
  assign rd_en = acc_en && !acc_wr;

  slr_status_enc #(.DW(DATA_W)) u_stat (
    .phy_rdy    (phy_rdy),
    .force_rdy  (phy_q[1]),
    .dev_detect (dev_detect),
    .offline    (ctl_q.det == DET_OFFLINE),
    .pwr_state  (pwr_state),
    .stat_word  (stat_word)
  );

  slr_err_reg #(.DW(DATA_W), .W1C_MASK(SERR_W1C), .RW_MASK(SERR_RW)) u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en && (acc_addr == ADR_SERR)),
    .wdata (acc_wdata),
    .evt   (err_evt),
    .err_q (err_q)
  );

  slr_ctl_regs #(.DW(DATA_W), .AW(ADDR_W), .NPAT(NPAT)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (acc_addr),
    .wdata     (acc_wdata),
    .ctl_q     (ctl_q),
    .tctl_q    (tctl_q),
    .pat_flat  (pat_flat),
    .sys_txo_q (sys_txo_q),
    .phy_q     (phy_q),
    .go_q      (go_q)
  );

  // read multiplexer
  always_comb begin
    rd_mux = '0;
    case (acc_addr)
      ADR_STAT: rd_mux = stat_word;
      ADR_SERR: rd_mux = err_q;
      ADR_SCTL: rd_mux = {{(DATA_W-FW){1'b0}}, ctl_q};
      ADR_TCTL: begin
        rd_mux[TCTL_LPBK]  = tctl_q[0];
        rd_mux[TCTL_SCRAM] = tctl_q[1];
        rd_mux[TCTL_TXO]   = tctl_q[2];
      end
      ADR_PAT0:         rd_mux = pat_flat[0 +: DATA_W];
      ADR_PAT0 + 4'h1:  rd_mux = pat_flat[DATA_W +: DATA_W];
      ADR_SYS:          rd_mux[SYS_TXO] = sys_txo_q;
      ADR_PHY:          rd_mux[1:0] = phy_q;
      default:          rd_mux = '0;
    endcase
  end

  assign rd_data_d = rd_en ? rd_mux : rd_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid    = rd_valid_q;
  assign rd_data     = rd_data_q;
  assign if_reset    = ctl_q.det[0];
  assign phy_offline = (ctl_q.det == DET_OFFLINE);
  assign partial_dis = (ctl_q.ipm == 4'h1) || (ctl_q.ipm == 4'h3);
  assign slumber_dis = (ctl_q.ipm == 4'h2) || (ctl_q.ipm == 4'h3);
  assign tx_enable   = phy_q[0];
  assign force_rdy   = phy_q[1];
  assign txonly_mode = sys_txo_q && phy_q[1];
  assign bist_start  = go_q;
  assign bist_lpbk   = tctl_q[0];
  assign bist_scram  = tctl_q[1];
  assign bist_txonly = tctl_q[2];
  assign bist_pat0   = pat_flat[0 +: DATA_W];
  assign bist_pat1   = pat_flat[DATA_W +: DATA_W];

endmodule

// File: rtl/slr_regfile_chk.sv
module slr_regfile_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_wdata,
  input logic              rd_valid,
  input logic              if_reset,
  input logic              phy_offline,
  input logic              tx_enable,
  input logic              force_rdy,
  input logic              txonly_mode,
  input logic              bist_start
);

  AST_RD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_en && !acc_wr)); // R1

  AST_RST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_reset) |-> $past(acc_en && acc_wr && acc_addr == 4'h2 && acc_wdata[0])); // R6

  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (if_reset && !(acc_en && acc_wr && acc_addr == 4'h2)) |=> if_reset); // R6

  AST_OFFLINE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_offline) |-> $past(acc_en && acc_wr && acc_addr == 4'h2 && acc_wdata[3:0] == 4'h4)); // R6

  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |=> !bist_start); // R9

  AST_GO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |-> $past(acc_en && acc_wr && acc_addr == 4'h6 && acc_wdata[0])); // R9

  AST_TXEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_enable) |-> $past(acc_en && acc_wr && acc_addr == 4'h9 && !acc_wdata[0])); // R10

  AST_TXO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    txonly_mode |-> force_rdy); // R11

endmodule

bind slr_regfile slr_regfile_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_en      (acc_en),
  .acc_wr      (acc_wr),
  .acc_addr    (acc_addr),
  .acc_wdata   (acc_wdata),
  .rd_valid    (rd_valid),
  .if_reset    (if_reset),
  .phy_offline (phy_offline),
  .tx_enable   (tx_enable),
  .force_rdy   (force_rdy),
  .txonly_mode (txonly_mode),
  .bist_start  (bist_start)
);

// File: tb/slr_regfile_tb.sv
module slr_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [3:0]  acc_addr;
  logic [31:0] acc_wdata;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        phy_rdy, dev_detect;
  logic [1:0]  pwr_state;
  logic [31:0] err_evt;
  logic        if_reset, phy_offline, partial_dis, slumber_dis;
  logic        tx_enable, force_rdy, txonly_mode, bist_start;
  logic        bist_lpbk, bist_scram, bist_txonly;
  logic [31:0] bist_pat0, bist_pat1;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  slr_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .phy_rdy(phy_rdy), .dev_detect(dev_detect),
    .pwr_state(pwr_state), .err_evt(err_evt), .if_reset(if_reset),
    .phy_offline(phy_offline), .partial_dis(partial_dis),
    .slumber_dis(slumber_dis), .tx_enable(tx_enable), .force_rdy(force_rdy),
    .txonly_mode(txonly_mode), .bist_start(bist_start), .bist_lpbk(bist_lpbk),
    .bist_scram(bist_scram), .bist_txonly(bist_txonly),
    .bist_pat0(bist_pat0), .bist_pat1(bist_pat1)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R1: unexpected read result actual %h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    acc_en = 1; acc_wr = 0; acc_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    acc_en = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; acc_en = 0; acc_wr = 0; acc_addr = 0; acc_wdata = 0;
    phy_rdy = 0; dev_detect = 0; pwr_state = 2'b00; err_evt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    check("R6 reset if_reset", {31'b0, if_reset}, 32'h0);
    check("R10 reset tx_enable", {31'b0, tx_enable}, 32'h1);
    check("R10 reset force_rdy", {31'b0, force_rdy}, 32'h0);
    check("R9 reset bist_start", {31'b0, bist_start}, 32'h0);
    rd(4'h2, 32'h0000_0010, "R7 control reset value");
    rd(4'h9, 32'h0000_0001, "R10 phy control reset");
    rd(4'h1, 32'h0, "R4 error reset");
    rd(4'h0, 32'h0, "R2 status no device");

    // status encoding patterns
    dev_detect = 1; pwr_state = 2'b01;
    rd(4'h0, 32'h0000_0001, "R3 present not ready, spd/ipm zero");
    phy_rdy = 1; pwr_state = 2'b00;
    rd(4'h0, 32'h0000_0113, "R3 ready active");
    pwr_state = 2'b01;
    rd(4'h0, 32'h0000_0213, "R3 ready partial");
    pwr_state = 2'b10;
    rd(4'h0, 32'h0000_0613, "R3 ready slumber");
    pwr_state = 2'b11;
    rd(4'h0, 32'h0000_0013, "R3 ready reserved power");
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0000_0013, "R1 status write ignored");
    pwr_state = 2'b10;

    // error slot
    @(negedge clk); err_evt = 32'hFFFF_FFFF;
    @(negedge clk); err_evt = 32'h0;
    rd(4'h1, 32'h03FD_0F03, "R4 events set sticky bits only");
    wr(4'h1, 32'h0000_0F00);
    rd(4'h1, 32'h03FD_0003, "R4 write-1 clears selected bits");
    wr(4'h1, 32'h0002_0000);
    rd(4'h1, 32'h03FF_0003, "R4 bit17 plain write");
    wr(4'h1, 32'h03FD_0003);
    rd(4'h1, 32'h0, "R4 clear all, bit17 written 0");
    @(negedge clk);
    acc_en = 1; acc_wr = 1; acc_addr = 4'h1; acc_wdata = 32'h0000_0001; err_evt = 32'h0000_0001;
    @(negedge clk);
    acc_en = 0; acc_wr = 0; err_evt = 0;
    rd(4'h1, 32'h0000_0001, "R5 event beats clear");
    wr(4'h1, 32'h0000_0001);
    rd(4'h1, 32'h0, "R5 later clear works");

    // control
    wr(4'h2, 32'h0000_0301);
    check("R6 if_reset raised", {31'b0, if_reset}, 32'h1);
    check("R7 partial_dis code 3", {31'b0, partial_dis}, 32'h1);
    check("R7 slumber_dis code 3", {31'b0, slumber_dis}, 32'h1);
    rd(4'h2, 32'h0000_0301, "R7 control readback");
    repeat (5) @(negedge clk);
    wr(4'h3, 32'h0);
    check("R6 if_reset held", {31'b0, if_reset}, 32'h1);
    wr(4'h2, 32'h0000_0114);
    check("R6 if_reset released", {31'b0, if_reset}, 32'h0);
    check("R6 phy_offline", {31'b0, phy_offline}, 32'h1);
    check("R7 partial only", {30'b0, partial_dis, slumber_dis}, 32'h2);
    rd(4'h0, 32'h0000_0614, "R2 offline status");
    wr(4'h2, 32'h0000_0210);
    check("R6 offline dropped", {31'b0, phy_offline}, 32'h0);
    check("R7 slumber only", {30'b0, partial_dis, slumber_dis}, 32'h1);
    wr(4'h2, 32'h0000_0010);

    // self-test options and patterns
    wr(4'h3, 32'hFFFF_FFFF);
    rd(4'h3, 32'h00B0_0000, "R8 option slot keeps bits 20,21,23");
    check("R8 option outputs", {29'b0, bist_txonly, bist_scram, bist_lpbk}, 32'h7);
    wr(4'h3, 32'h0010_0000);
    check("R8 loopback only", {29'b0, bist_txonly, bist_scram, bist_lpbk}, 32'h1);
    wr(4'h4, 32'hA5A5_1234);
    wr(4'h5, 32'h5A5A_CDEF);
    check("R8 pattern 0 out", bist_pat0, 32'hA5A5_1234);
    check("R8 pattern 1 out", bist_pat1, 32'h5A5A_CDEF);
    rd(4'h5, 32'h5A5A_CDEF, "R8 pattern 1 readback");

    // system control and phy control
    wr(4'h6, 32'h0000_0009);
    check("R9 start pulse high", {31'b0, bist_start}, 32'h1);
    @(negedge clk);
    check("R9 start pulse one cycle", {31'b0, bist_start}, 32'h0);
    rd(4'h6, 32'h0000_0008, "R9 start bit reads 0");
    check("R11 txonly gated off", {31'b0, txonly_mode}, 32'h0);
    phy_rdy = 0; dev_detect = 0; pwr_state = 2'b01;
    wr(4'h9, 32'h0000_0002);
    check("R10 force_rdy set", {31'b0, force_rdy}, 32'h1);
    check("R10 tx_enable cleared", {31'b0, tx_enable}, 32'h0);
    check("R11 txonly active", {31'b0, txonly_mode}, 32'h1);
    rd(4'h0, 32'h0000_0213, "R2 force ready counts as established");
    rd(4'h9, 32'h0000_0002, "R10 phy control readback");
    wr(4'h9, 32'hFFFF_FFFD);
    rd(4'h9, 32'h0000_0001, "R10 only two bits kept");

    // unmapped
    wr(4'h7, 32'hFFFF_FFFF);
    rd(4'h7, 32'h0, "R1 unmapped slot 7");
    wr(4'hF, 32'h1234_5678);
    rd(4'hF, 32'h0, "R1 unmapped slot 15");
    rd(4'h2, 32'h0000_0010, "R1 control untouched by unmapped write");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R1: pending reads actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule